// File: doc/BRIEF.md
# Halt-aware watchdog timer

This block is a watchdog that counts down on every CPU clock and raises a system reset when the top bit of its 7-bit counter drops from one to zero. Software keeps the chip alive by reloading the counter through a one-byte control register. A strap input picks the enable policy. In strapped-on mode the watchdog counts from reset onward. In software mode it starts disabled, and once software arms it, it stays armed until the next system reset.

The block also decides what happens when the CPU enters its low-power halt state. With the watchdog running, halt entry either trips a reset or freezes the counter. The choice depends on a halt-permission control bit and on a USB/suspend flag. An external wake interrupt ends the halt. The counter then stays frozen for a fixed 514 clocks before it resumes from the value it held. The counter also freezes whenever the oscillator-running indication is low. Every reset this block requests comes out as a registered pulse of fixed length.

Top module: `halt_watchdog`

## Requirements
- R1: After system reset in software mode, `rd_data` reads 0x7F, `wdg_rst` is low and `counting` is low. With no register write, the value stays 0x7F.
- R2: In software mode, a write with `wr_data[7]`=1 arms the watchdog. The arm state reads back in `rd_data[7]` and stays set through later writes with bit 7 clear.
- R3: With `hw_mode`=1 the watchdog counts from the first clock after reset. `rd_data[7]` reads 1, and bit 7 of a write changes nothing.
- R4: While `counting` is high, the counter (`rd_data[6:0]`) drops by one per clock. The step from 0x40 to 0x3F starts a reset pulse in the following cycle.
- R5: A write with `wr_data[6]`=1 loads `wr_data[6:0]` into the counter. This refresh takes precedence over that cycle's decrement.
- R6: A write with `wr_data[6]`=0 starts a reset pulse if the watchdog is armed after the write, strapped on or set by that write's bit 7. The same write to a disarmed software-mode watchdog only loads the counter.
- R7: A halt strobe while armed, with `halt_ok`=0 and `usb_susp`=0, starts a reset pulse.
- R8: A halt strobe with `halt_ok`=1 enters halt without a reset. While halted, the counter holds and `counting` is low.
- R9: While `usb_susp`=1, a halt strobe never causes a reset and always enters halt.
- R10: A `wake_irq` while halted leaves halt. The counter then holds for 514 clocks and afterwards resumes from its held value.
- R11: While `osc_run`=0, the counter holds and `counting` is low.
- R12: `wdg_rst` is high for exactly 4 consecutive cycles, starting the cycle after the triggering edge. During the pulse the counter holds and further triggers are ignored.
- R13: A system reset taken while halted and armed in software mode returns the watchdog to its disarmed reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low system reset |
| hw_mode | input | 1 | Strap: 1 = always on, 0 = software armed |
| halt_ok | input | 1 | Control bit permitting halt while armed |
| usb_susp | input | 1 | USB or suspend mode active |
| halt_req | input | 1 | One-cycle halt-entry strobe |
| wake_irq | input | 1 | External wake interrupt |
| osc_run | input | 1 | Oscillator running indication |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Bit 7 arm, bits 6:0 counter value |
| rd_data | output | 8 | Bit 7 armed state, bits 6:0 counter |
| wdg_rst | output | 1 | Watchdog reset pulse |
| counting | output | 1 | Counter is decrementing this cycle |

## Verification
Every cycle, the assertions check that the arm state is sticky and that each counting cycle takes exactly one step down. They also check that a refresh loads the written value, that a 0x40 step trips a reset, and that the counter holds while halted, waking or with the oscillator stopped. A halt strobe under the USB/suspend flag must not trip a reset, and a started pulse must last more than one cycle. Only the bench scenarios show the exact 514-clock wake delay, the full 4-cycle pulse width, and the forced-reset write in both modes. The same holds for halt-triggered resets depending on `halt_ok`, and for the return to the disarmed state after a reset taken during halt.

// File: rtl/halt_watchdog.sv
`timescale 1ns/1ps
module halt_watchdog #(
  parameter int CNT_W      = 7,
  parameter int PULSE_LEN  = 4,
  parameter int WAKE_DELAY = 514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_mode,
  input  logic             halt_ok,
  input  logic             usb_susp,
  input  logic             halt_req,
  input  logic             wake_irq,
  input  logic             osc_run,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W:0]   rd_data,
  output logic             wdg_rst,
  output logic             counting
);
  localparam int TOP  = CNT_W - 1;
  localparam int WK_W = $clog2(WAKE_DELAY + 1);
  localparam int PL_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TRIP_AT  = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [WK_W-1:0]  WAKE_LD  = WK_W'(WAKE_DELAY);
  localparam logic [PL_W-1:0]  PULSE_LD = PL_W'(PULSE_LEN);

  logic             act_q, halted_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WK_W-1:0]  wake_q;
  logic [PL_W-1:0]  pulse_q;

  logic enabled, pulse_on, waking, step_trip, halt_trip, wr_trip, trip;

  assign enabled   = hw_mode | act_q;
  assign pulse_on  = pulse_q != '0;
  assign waking    = wake_q != '0;
  assign counting  = enabled & osc_run & ~halted_q & ~waking & ~pulse_on;
  assign wr_trip   = wr_en & (enabled | wr_data[CNT_W]) & ~wr_data[TOP];
  assign step_trip = counting & ~wr_en & (cnt_q == TRIP_AT);
  assign halt_trip = halt_req & ~halted_q & enabled & ~halt_ok & ~usb_susp;
  assign trip      = (wr_trip | step_trip | halt_trip) & ~pulse_on;
  assign wdg_rst   = pulse_on;
  assign rd_data   = {enabled, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (wr_en && wr_data[CNT_W]) begin
      act_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (wr_en) begin
      cnt_q <= wr_data[CNT_W-1:0];
    end else if (counting) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      wake_q   <= '0;
    end else if (halted_q) begin
      if (wake_irq) begin
        halted_q <= 1'b0;
        wake_q   <= WAKE_LD;
      end
    end else if (halt_req && !halt_trip) begin
      halted_q <= 1'b1;
      wake_q   <= '0;
    end else if (waking) begin
      wake_q <= wake_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (trip) begin
      pulse_q <= PULSE_LD;
    end else if (pulse_on) begin
      pulse_q <= pulse_q - 1'b1;
    end
  end

  p_sticky_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CNT_W] |=> rd_data[CNT_W]);

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_trip_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !wr_en && cnt_q == TRIP_AT && !wdg_rst) |=> $rose(wdg_rst));

  p_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[TOP]) |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !wr_en) |=> $stable(cnt_q));

  p_usb_no_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && usb_susp && !wr_en && !wdg_rst && !(counting && cnt_q == TRIP_AT))
      |=> !wdg_rst);

  p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (waking && !wr_en) |=> $stable(cnt_q));

  p_osc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !wr_en) |=> $stable(cnt_q));

  generate
    if (PULSE_LEN > 1) begin : g_pulse_chk
      p_pulse_width_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_rst) |=> wdg_rst);
    end
  endgenerate
endmodule

// File: tb/test_halt_watchdog.sv
`timescale 1ns/1ps
module test_halt_watchdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b0, halt_ok = 1'b0, usb_susp = 1'b0;
  logic halt_req = 1'b0, wake_irq = 1'b0, osc_run = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wdg_rst, counting;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  halt_watchdog i_halt_watchdog (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .halt_ok(halt_ok),
    .usb_susp(usb_susp), .halt_req(halt_req), .wake_irq(wake_irq),
    .osc_run(osc_run), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdg_rst(wdg_rst), .counting(counting)
  );

  function automatic int exp_after(input int v, input int n);
    return (v - n) & 32'h7F;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic hw);
    hw_mode = hw; rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic halt_strobe();
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240);
    step();
    do_reset(1'b0);
    check(rd_data == 8'h7F, "R1 reset value", rd_data, 8'h7F);
    check(!wdg_rst, "R1 no reset pulse", wdg_rst, 0);
    check(!counting, "R1 idle", counting, 0);
    repeat (10) step();
    check(rd_data == 8'h7F, "R1 disarmed hold", rd_data, 8'h7F);

    wr(8'h20);
    check(rd_data == 8'h20, "R6 disarmed load", rd_data, 8'h20);
    check(!wdg_rst, "R6 disarmed no trip", wdg_rst, 0);

    wr(8'hFF);
    check(rd_data == 8'hFF, "R2 arm", rd_data, 8'hFF);
    step();
    check(rd_data == 8'hFE, "R4 decrement", rd_data, 8'hFE);
    wr(8'h70);
    check(rd_data == 8'hF0, "R2 sticky / R5 refresh", rd_data, 8'hF0);
    repeat (48) step();
    check(rd_data == 8'hC0 && !wdg_rst, "R4 before trip", rd_data, 8'hC0);
    step();
    check(wdg_rst == 1'b1, "R4 trip", wdg_rst, 1);
    check(rd_data == 8'hBF, "R4 value at trip", rd_data, 8'hBF);
    for (int k = 0; k < 3; k++) begin
      step();
      check(wdg_rst == 1'b1, "R12 pulse held", wdg_rst, 1);
    end
    step();
    check(!wdg_rst, "R12 pulse ends", wdg_rst, 0);
    check(rd_data == 8'hBF, "R12 counter held", rd_data, 8'hBF);

    do_reset(1'b0);
    wr(8'hA5);
    check(wdg_rst == 1'b1, "R6 forced reset", wdg_rst, 1);

    do_reset(1'b0);
    halt_ok = 1'b0; usb_susp = 1'b0;
    wr(8'hFF);
    halt_strobe();
    check(wdg_rst == 1'b1, "R7 halt trips", wdg_rst, 1);

    do_reset(1'b0);
    halt_ok = 1'b1;
    wr(8'hFF);
    repeat (5) step();
    check(rd_data == 8'hFA, "R4 run", rd_data, 8'hFA);
    halt_strobe();
    check(rd_data == 8'hF9 && !counting, "R8 enter halt", rd_data, 8'hF9);
    repeat (20) step();
    check(rd_data == 8'hF9 && !wdg_rst && !counting, "R8 frozen", rd_data, 8'hF9);
    wake_irq = 1'b1;
    step();
    wake_irq = 1'b0;
    check(rd_data == 8'hF9 && !counting, "R10 wake hold", rd_data, 8'hF9);
    repeat (513) step();
    check(rd_data == 8'hF9 && !counting, "R10 still holding", counting, 0);
    step();
    check(counting == 1'b1 && rd_data == 8'hF9, "R10 resume", counting, 1);
    step();
    check(rd_data == 8'hF8, "R10 counts again", rd_data, 8'hF8);
    osc_run = 1'b0;
    repeat (10) step();
    check(rd_data == 8'hF8 && !counting, "R11 osc stopped", rd_data, 8'hF8);
    osc_run = 1'b1;
    step();
    check(rd_data == 8'hF7, "R11 osc restarted", rd_data, 8'hF7);

    do_reset(1'b0);
    halt_ok = 1'b0; usb_susp = 1'b1;
    wr(8'hFF);
    halt_strobe();
    check(!wdg_rst && !counting, "R9 usb halt no trip", wdg_rst, 0);
    repeat (10) step();
    check(!wdg_rst && rd_data == 8'hFE, "R9 halted quietly", rd_data, 8'hFE);
    usb_susp = 1'b0;
    do_reset(1'b0);
    check(rd_data == 8'h7F && !counting, "R13 disarmed after halt reset", rd_data, 8'h7F);
    repeat (5) step();
    check(rd_data == 8'h7F, "R13 stays disarmed", rd_data, 8'h7F);

    do_reset(1'b1);
    check(rd_data == 8'hFE && counting, "R3 strapped on", rd_data, 8'hFE);
    wr(8'h7F);
    check(rd_data == 8'hFF, "R3 bit7 ignored", rd_data, 8'hFF);
    wr(8'h30);
    check(wdg_rst == 1'b1, "R3 R6 forced reset strapped", wdg_rst, 1);

    do_reset(1'b0);
    wr(8'hFF);
    for (int it = 0; it < 30; it++) begin
      int v, n;
      v = 65 + int'($urandom_range(0, 62));
      n = int'($urandom_range(0, v - 65));
      wr(8'h80 | 8'(v));
      repeat (n) step();
      check(rd_data == (8'h80 | 8'(exp_after(v, n))) && !wdg_rst, "R5 random refresh",
            rd_data, 8'h80 | 8'(exp_after(v, n)));
      if (it % 6 == 0) begin
        repeat (v - 64 - n) step();
        check(!wdg_rst, "R4 random pre-trip", wdg_rst, 0);
        step();
        check(wdg_rst == 1'b1, "R4 random trip", wdg_rst, 1);
        do_reset(1'b0);
        wr(8'hFF);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule